// File: doc/BRIEF.md
# Oversampled Serial Receiver with Multiprocessor Filtering

This block turns an asynchronous serial line into characters. Each bit is sampled at a fixed oversampling rate, and a majority vote of three samples around mid-bit decides its value. A start bit that is high again at half a bit time is thrown away as a glitch. Each frame is a low start bit, then 7 or 8 data bits sent LSB-first or MSB-first, then an optional address-marker bit, then an optional parity bit, then a high stop bit. A plain clock divider makes the oversampling tick.

Each completed character is classified as clean, erroneous (parity or framing), or a break. It is then offered to a filter, which decides whether it is stored and raises the ready flag. The filter has an erroneous-character enable, a break enable and a dormant setting. The dormant setting admits only address-marked characters, or characters that follow a long idle line. The stored character leaves through a valid/ready pair. The receiver never stalls. A consumer that does not take a character before the next admitted one arrives loses it: the buffer is overwritten and the overrun flag is set. A loopback select takes the receive line from the local transmit pin, and a synchronous software reset clears the whole block.

Top module: `uart_rx_mp`

## Requirements
- R1: A frame is start (0), data bits, [marker bit when address mode], [parity when enabled], stop (1). When `cfg_msb`=0 the first data bit received is stored at `rx_data[0]`. When `cfg_msb`=1 it is stored at the highest data bit position.
- R2: When `cfg_seven`=1, 7 data bits are received and `rx_data[7]` reads 0. When it is 0, 8 bits are received.
- R3: Each bit is the majority of three oversampled samples taken at mid-bit. A low pulse shorter than half a bit leaves `busy` and `rx_valid` low.
- R4: With parity enabled, the data bits, the marker bit and the parity bit together must have an odd count of ones (`cfg_par_odd`=1) or an even count (`cfg_par_odd`=0). Otherwise `st_pe` is set. `st_pe` reads 0 whenever `cfg_par_en`=0.
- R5: A stop bit sampled low sets `st_fe`.
- R6: A frame whose data, marker, parity and stop bits are all low is a break. It sets `st_brk` and `st_fe`, and it is stored only when `cfg_brk_ie`=1, whatever `cfg_err_ie` is set to.
- R7: A character with a framing or parity error that is not a break is discarded when `cfg_err_ie`=0. It is stored with its flags when `cfg_err_ie`=1.
- R8: In address mode (`cfg_mp_addr`=1) with `cfg_dormant`=1, only characters whose marker bit is 1 are stored. `st_addr` holds the stored marker bit.
- R9: In idle-line mode (`cfg_mp_addr`=0), a character is marked when at least IDLE_BITS bit times of high line came before its start bit. With `cfg_dormant`=1 only marked characters are stored, and `st_addr` shows the mark.
- R10: A character stored while `rx_valid`=1 and not taken overwrites `rx_data` and sets `st_oe`.
- R11: `st_err` is set when a stored character brings `st_fe`, `st_pe` or `st_oe`. A transfer (`rx_valid` and `rx_ready` both high) clears `rx_valid`, `st_err` and `st_oe` on the next cycle.
- R12: When `cfg_loop`=1 the receiver takes its line from `txd_loc` and ignores `rxd`.
- R13: While `sw_rst`=1 the block holds its reset state: `busy`, `rx_valid`, `st_err` and `st_oe` are low.
- R14: `busy` is high from a detected start bit until the stop bit has been sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_rst | input | 1 | Synchronous software reset |
| cfg_div | input | DIV_W | Clocks per oversampling tick minus one |
| cfg_seven | input | 1 | 7-bit characters when 1 |
| cfg_msb | input | 1 | MSB-first order when 1 |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_mp_addr | input | 1 | Address-bit mode when 1, idle-line mode when 0 |
| cfg_dormant | input | 1 | Store only marked characters |
| cfg_err_ie | input | 1 | Store erroneous characters |
| cfg_brk_ie | input | 1 | Store break characters |
| cfg_loop | input | 1 | Receive from txd_loc |
| rxd | input | 1 | Serial receive line |
| txd_loc | input | 1 | Local transmit line, used in loopback |
| rx_data | output | 8 | Stored character |
| rx_valid | output | 1 | Stored character is waiting |
| rx_ready | input | 1 | Consumer takes the character |
| st_addr | output | 1 | Marker (address bit or idle) of the stored character |
| st_fe | output | 1 | Framing error of the stored character |
| st_pe | output | 1 | Parity error of the stored character |
| st_brk | output | 1 | Stored character is a break |
| st_oe | output | 1 | Overrun |
| st_err | output | 1 | Summary error |
| busy | output | 1 | Reception in progress |

## Verification
The bench builds the block with OSR=16, DIV_W=4 and IDLE_BITS=4, and drives `cfg_div`=0 so that every clock is an oversampling tick. One bit is then exactly 16 clocks. The short idle threshold lets the bench both reject a character after a 2-bit gap and accept one after a gap of more than 4 bit times, all within a few hundred cycles. Every pairing of length and order, both parity senses, and each filter decision are reached in a few thousand cycles.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef struct packed {
    logic [7:0] data;
    logic       mark;
    logic       fe;
    logic       pe;
    logic       brk;
  } rx_char_t;

  typedef enum logic [1:0] {S_IDLE, S_START, S_BITS} rx_state_t;
endpackage

// File: rtl/uart_rx_baud.sv
module uart_rx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OSR       = 16,
  parameter int IDLE_BITS = 10
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr,
  input  logic     tick,
  input  logic     line,
  input  logic     cfg_seven,
  input  logic     cfg_msb,
  input  logic     cfg_par_en,
  input  logic     cfg_par_odd,
  input  logic     cfg_mp_addr,
  output logic     busy,
  output logic     done,
  output rx_char_t chr
);
  localparam int CW      = $clog2(OSR);
  localparam int IDLE_TK = OSR * IDLE_BITS;
  localparam int IW      = $clog2(IDLE_TK + 1);
  localparam logic [CW-1:0] C_MID  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] C_MID1 = CW'(OSR / 2);
  localparam logic [CW-1:0] C_MID2 = CW'(OSR / 2 + 1);
  localparam logic [CW-1:0] C_LAST = CW'(OSR - 1);
  localparam logic [IW-1:0] IDLE_MAX = IW'(IDLE_TK);

  rx_state_t     st;
  logic [1:0]    sync;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idle_cnt;
  logic          idle_pre, s0, s1, acc, orv, abit;
  logic [3:0]    bi;
  logic [7:0]    dat;

  logic       ln, vote;
  logic [3:0] nd, pos_stop;
  logic [2:0] idx;

  assign ln       = sync[1];
  assign vote     = (s0 & s1) | (s0 & ln) | (s1 & ln);
  assign nd       = cfg_seven ? 4'd7 : 4'd8;
  assign pos_stop = nd + {3'b0, cfg_mp_addr} + {3'b0, cfg_par_en};
  assign idx      = cfg_msb ? 3'(nd - 4'd1 - bi) : bi[2:0];
  assign busy     = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sync <= 2'b11; cnt <= '0; idle_cnt <= '0; idle_pre <= 1'b0;
      s0 <= 1'b0; s1 <= 1'b0; acc <= 1'b0; orv <= 1'b0; abit <= 1'b0;
      bi <= '0; dat <= '0; done <= 1'b0; chr <= '0;
    end else if (clr) begin
      st <= S_IDLE; sync <= 2'b11; cnt <= '0; idle_cnt <= '0; idle_pre <= 1'b0;
      s0 <= 1'b0; s1 <= 1'b0; acc <= 1'b0; orv <= 1'b0; abit <= 1'b0;
      bi <= '0; dat <= '0; done <= 1'b0; chr <= '0;
    end else begin
      sync <= {sync[0], line};
      done <= 1'b0;
      if (tick) begin
        if (st == S_IDLE) begin
          if (!ln) begin
            st       <= S_START;
            cnt      <= '0;
            idle_pre <= (idle_cnt == IDLE_MAX);
            idle_cnt <= '0;
          end else if (idle_cnt != IDLE_MAX) begin
            idle_cnt <= idle_cnt + 1'b1;
          end
        end else begin
          cnt <= (cnt == C_LAST) ? '0 : cnt + 1'b1;
          if (cnt == C_MID)  s0 <= ln;
          if (cnt == C_MID1) s1 <= ln;
          if (cnt == C_MID2) begin
            if (st == S_START) begin
              if (vote) st <= S_IDLE;
              bi <= '0; acc <= 1'b0; orv <= 1'b0; dat <= '0; abit <= 1'b0;
            end else begin
              acc <= acc ^ vote;
              orv <= orv | vote;
              bi  <= bi + 1'b1;
              if (bi < nd) begin
                dat[idx] <= vote;
              end else if (bi == pos_stop) begin
                done     <= 1'b1;
                st       <= S_IDLE;
                chr.data <= dat;
                chr.mark <= cfg_mp_addr ? abit : idle_pre;
                chr.fe   <= ~vote;
                chr.pe   <= cfg_par_en & (acc != cfg_par_odd);
                chr.brk  <= ~(orv | vote);
              end else if (cfg_mp_addr && bi == nd) begin
                abit <= vote;
              end
            end
          end
          if (cnt == C_LAST && st == S_START) st <= S_BITS;
        end
      end
    end
  end
endmodule

// File: rtl/uart_rx_accept.sv
module uart_rx_accept
  import uart_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       done,
  input  rx_char_t   chr,
  input  logic       cfg_dormant,
  input  logic       cfg_err_ie,
  input  logic       cfg_brk_ie,
  input  logic       cfg_par_en,
  input  logic       rx_ready,
  output logic       pass,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       st_addr,
  output logic       st_fe,
  output logic       st_pe,
  output logic       st_brk,
  output logic       st_oe,
  output logic       st_err
);
  logic pe_q, take, ovr, oe_keep, err_ok;

  assign err_ok  = chr.brk ? cfg_brk_ie : ((chr.fe | chr.pe) ? cfg_err_ie : 1'b1);
  assign pass    = err_ok && (!cfg_dormant || chr.mark);
  assign take    = rx_valid && rx_ready;
  assign ovr     = rx_valid && !rx_ready;
  assign oe_keep = ovr | (st_oe & ~take);
  assign st_pe   = pe_q & cfg_par_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0; rx_data <= '0; st_addr <= 1'b0; st_fe <= 1'b0;
      pe_q <= 1'b0; st_brk <= 1'b0; st_oe <= 1'b0; st_err <= 1'b0;
    end else if (clr) begin
      rx_valid <= 1'b0; rx_data <= '0; st_addr <= 1'b0; st_fe <= 1'b0;
      pe_q <= 1'b0; st_brk <= 1'b0; st_oe <= 1'b0; st_err <= 1'b0;
    end else if (done && pass) begin
      rx_valid <= 1'b1;
      rx_data  <= chr.data;
      st_addr  <= chr.mark;
      st_fe    <= chr.fe;
      pe_q     <= chr.pe;
      st_brk   <= chr.brk;
      st_oe    <= oe_keep;
      st_err   <= chr.fe | chr.pe | oe_keep;
    end else if (take) begin
      rx_valid <= 1'b0;
      st_oe    <= 1'b0;
      st_err   <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_mp.sv
module uart_rx_mp
  import uart_rx_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int OSR       = 16,
  parameter int IDLE_BITS = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_rst,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_seven,
  input  logic             cfg_msb,
  input  logic             cfg_par_en,
  input  logic             cfg_par_odd,
  input  logic             cfg_mp_addr,
  input  logic             cfg_dormant,
  input  logic             cfg_err_ie,
  input  logic             cfg_brk_ie,
  input  logic             cfg_loop,
  input  logic             rxd,
  input  logic             txd_loc,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic             st_addr,
  output logic             st_fe,
  output logic             st_pe,
  output logic             st_brk,
  output logic             st_oe,
  output logic             st_err,
  output logic             busy
);
  logic     tick, line, frm_done, acc_pass;
  rx_char_t frm_chr;

  assign line = cfg_loop ? txd_loc : rxd;

  uart_rx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .clr(sw_rst), .div(cfg_div), .tick(tick)
  );

  uart_rx_frame #(.OSR(OSR), .IDLE_BITS(IDLE_BITS)) u_frame (
    .clk(clk), .rst_n(rst_n), .clr(sw_rst), .tick(tick), .line(line),
    .cfg_seven(cfg_seven), .cfg_msb(cfg_msb), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_mp_addr(cfg_mp_addr),
    .busy(busy), .done(frm_done), .chr(frm_chr)
  );

  uart_rx_accept u_accept (
    .clk(clk), .rst_n(rst_n), .clr(sw_rst), .done(frm_done), .chr(frm_chr),
    .cfg_dormant(cfg_dormant), .cfg_err_ie(cfg_err_ie), .cfg_brk_ie(cfg_brk_ie),
    .cfg_par_en(cfg_par_en), .rx_ready(rx_ready), .pass(acc_pass),
    .rx_valid(rx_valid), .rx_data(rx_data), .st_addr(st_addr), .st_fe(st_fe),
    .st_pe(st_pe), .st_brk(st_brk), .st_oe(st_oe), .st_err(st_err)
  );
endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic sw_rst,
  input logic done,
  input logic pass,
  input logic rx_valid,
  input logic rx_ready,
  input logic busy,
  input logic st_err,
  input logic st_fe,
  input logic st_pe,
  input logic st_oe,
  input logic st_brk
);
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    (rx_valid && rx_ready && !done) |=> (!rx_valid && !st_err)); // R11

  AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    $rose(st_err) |-> (st_fe || st_pe || st_oe)); // R11

  AST_BRK_FRAMING: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    st_brk |-> st_fe); // R6

  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    (done && pass && rx_valid && !rx_ready) |=> (st_oe && st_err && rx_valid)); // R10

  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    (done && !pass && !rx_valid) |=> !rx_valid); // R7

  AST_SWRST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (!busy && !rx_valid && !st_err && !st_oe)); // R13
endmodule

bind uart_rx_mp uart_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .done(frm_done), .pass(acc_pass),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .busy(busy), .st_err(st_err),
  .st_fe(st_fe), .st_pe(st_pe), .st_oe(st_oe), .st_brk(st_brk)
);

// File: tb/tb_uart_rx_mp.sv
module tb_uart_rx_mp;
  localparam int BITC = 16;

  typedef struct packed {
    logic       seven, msb, pen, podd, mpa, dorm, eie, bie;
    logic [7:0] data;
    logic       abit, badp, stop, acc;
    logic [7:0] edata;
    logic       efe, epe;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'hA5, 1'b0,1'b0,1'b1,1'b1, 8'hA5, 1'b0,1'b0}, // R1 lsb
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h3C, 1'b0,1'b0,1'b1,1'b1, 8'h3C, 1'b0,1'b0}, // R1 msb
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'hD3, 1'b0,1'b0,1'b1,1'b1, 8'h53, 1'b0,1'b0}, // R2 lsb
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h96, 1'b0,1'b0,1'b1,1'b1, 8'h16, 1'b0,1'b0}, // R2 msb
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h81, 1'b0,1'b0,1'b1,1'b1, 8'h81, 1'b0,1'b0}, // R4 even
    '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 8'h7E, 1'b0,1'b1,1'b1,1'b0, 8'h00, 1'b0,1'b0}, // R7 drop
    '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0, 8'h7E, 1'b0,1'b1,1'b1,1'b1, 8'h7E, 1'b0,1'b1}, // R4 odd bad
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h55, 1'b0,1'b0,1'b0,1'b0, 8'h00, 1'b0,1'b0}, // R7 fe drop
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 8'h55, 1'b0,1'b0,1'b0,1'b1, 8'h55, 1'b1,1'b0}, // R5
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0, 8'h11, 1'b0,1'b0,1'b1,1'b0, 8'h00, 1'b0,1'b0}, // R8 drop
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0, 8'h22, 1'b1,1'b0,1'b1,1'b1, 8'h22, 1'b0,1'b0}, // R8 keep
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 8'h33, 1'b0,1'b0,1'b1,1'b1, 8'h33, 1'b0,1'b0}, // R8 awake
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0, 8'h44, 1'b1,1'b0,1'b1,1'b1, 8'h44, 1'b0,1'b0}  // R4 with marker
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0, sw_rst = 1'b0;
  logic [3:0] cfg_div = 4'd0;
  logic cfg_seven = 0, cfg_msb = 0, cfg_par_en = 0, cfg_par_odd = 0, cfg_mp_addr = 0;
  logic cfg_dormant = 0, cfg_err_ie = 0, cfg_brk_ie = 0;
  logic ln = 1'b1, tb_loop = 1'b0, rx_ready = 1'b0;
  logic rxd, txd_loc, cfg_loop;
  logic [7:0] rx_data;
  logic rx_valid, st_addr, st_fe, st_pe, st_brk, st_oe, st_err, busy;
  int n_chk = 0, n_fail = 0;

  assign cfg_loop = tb_loop;
  assign rxd      = tb_loop ? 1'b0 : ln;
  assign txd_loc  = tb_loop ? ln : 1'b1;

  always #5 clk = ~clk;

  uart_rx_mp #(.DIV_W(4), .OSR(16), .IDLE_BITS(4)) dut (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .cfg_div(cfg_div),
    .cfg_seven(cfg_seven), .cfg_msb(cfg_msb), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_mp_addr(cfg_mp_addr), .cfg_dormant(cfg_dormant),
    .cfg_err_ie(cfg_err_ie), .cfg_brk_ie(cfg_brk_ie), .cfg_loop(cfg_loop),
    .rxd(rxd), .txd_loc(txd_loc), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .st_addr(st_addr), .st_fe(st_fe), .st_pe(st_pe),
    .st_brk(st_brk), .st_oe(st_oe), .st_err(st_err), .busy(busy)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  task automatic bit_out(input logic b);
    ln = b;
    repeat (BITC) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic ab, input logic badp, input logic stp);
    int  nd = cfg_seven ? 7 : 8;
    logic p = cfg_par_odd;
    for (int i = 0; i < nd; i++) p ^= d[i];
    if (cfg_mp_addr) p ^= ab;
    if (badp) p = ~p;
    bit_out(1'b0);
    chk("R14 busy during frame", {7'b0, busy}, 8'd1);
    for (int i = 0; i < nd; i++) bit_out(cfg_msb ? d[nd-1-i] : d[i]);
    if (cfg_mp_addr) bit_out(ab);
    if (cfg_par_en) bit_out(p);
    bit_out(stp);
    ln = 1'b1;
    repeat (2 * BITC) @(negedge clk);
  endtask

  task automatic send_break;
    ln = 1'b0;
    repeat (10 * BITC) @(negedge clk);
    ln = 1'b1;
    repeat (2 * BITC) @(negedge clk);
  endtask

  task automatic take;
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 reset valid", {7'b0, rx_valid}, 8'd0);
    chk("R13 reset busy", {7'b0, busy}, 8'd0);
    chk("R13 reset err", {7'b0, st_err}, 8'd0);
    chk("R13 reset data", rx_data, 8'h00);

    for (int v = 0; v < NV; v++) begin
      {cfg_seven, cfg_msb, cfg_par_en, cfg_par_odd, cfg_mp_addr, cfg_dormant, cfg_err_ie, cfg_brk_ie} =
        {VEC[v].seven, VEC[v].msb, VEC[v].pen, VEC[v].podd, VEC[v].mpa, VEC[v].dorm, VEC[v].eie, VEC[v].bie};
      @(negedge clk);
      send_frame(VEC[v].data, VEC[v].abit, VEC[v].badp, VEC[v].stop);
      chk($sformatf("R1/R7/R8 vec %0d valid", v), {7'b0, rx_valid}, {7'b0, VEC[v].acc});
      if (VEC[v].acc) begin
        chk($sformatf("R1/R2 vec %0d data", v), rx_data, VEC[v].edata);
        chk($sformatf("R5 vec %0d fe", v), {7'b0, st_fe}, {7'b0, VEC[v].efe});
        chk($sformatf("R4 vec %0d pe", v), {7'b0, st_pe}, {7'b0, VEC[v].epe});
        chk($sformatf("R11 vec %0d err", v), {7'b0, st_err}, {7'b0, VEC[v].efe | VEC[v].epe});
        chk($sformatf("R6 vec %0d brk", v), {7'b0, st_brk}, 8'd0);
        if (VEC[v].mpa) chk($sformatf("R8 vec %0d addr", v), {7'b0, st_addr}, {7'b0, VEC[v].abit});
        take();
        chk($sformatf("R11 vec %0d valid cleared", v), {7'b0, rx_valid}, 8'd0);
        chk($sformatf("R11 vec %0d err cleared", v), {7'b0, st_err}, 8'd0);
      end
    end

    {cfg_seven, cfg_msb, cfg_par_en, cfg_par_odd, cfg_mp_addr, cfg_dormant, cfg_err_ie, cfg_brk_ie} = 8'b0;

    // R4: parity flag masked once parity checking is off
    cfg_par_en = 1'b1; cfg_err_ie = 1'b1;
    @(negedge clk);
    send_frame(8'h0F, 1'b0, 1'b1, 1'b1);
    chk("R4 pe captured", {7'b0, st_pe}, 8'd1);
    cfg_par_en = 1'b0;
    @(negedge clk);
    chk("R4 pe masked when disabled", {7'b0, st_pe}, 8'd0);
    take();
    cfg_err_ie = 1'b0;

    // R3: short low glitch ignored
    ln = 1'b0;
    repeat (5) @(negedge clk);
    ln = 1'b1;
    repeat (40) @(negedge clk);
    chk("R3 glitch busy", {7'b0, busy}, 8'd0);
    chk("R3 glitch valid", {7'b0, rx_valid}, 8'd0);

    // R6: break suppressed without break enable even with error enable
    cfg_err_ie = 1'b1; cfg_brk_ie = 1'b0;
    @(negedge clk);
    send_break();
    chk("R6 break dropped", {7'b0, rx_valid}, 8'd0);
    cfg_brk_ie = 1'b1;
    @(negedge clk);
    send_break();
    chk("R6 break stored", {7'b0, rx_valid}, 8'd1);
    chk("R6 break flag", {7'b0, st_brk}, 8'd1);
    chk("R6 break framing", {7'b0, st_fe}, 8'd1);
    chk("R6 break data", rx_data, 8'h00);
    take();
    cfg_err_ie = 1'b0; cfg_brk_ie = 1'b0;

    // R10: overrun
    send_frame(8'hA1, 1'b0, 1'b0, 1'b1);
    chk("R10 first no overrun", {7'b0, st_oe}, 8'd0);
    send_frame(8'hB2, 1'b0, 1'b0, 1'b1);
    chk("R10 overrun flag", {7'b0, st_oe}, 8'd1);
    chk("R10 overwritten data", rx_data, 8'hB2);
    chk("R11 err on overrun", {7'b0, st_err}, 8'd1);
    take();
    chk("R11 oe cleared by read", {7'b0, st_oe}, 8'd0);
    chk("R11 err cleared by read", {7'b0, st_err}, 8'd0);

    // R9: idle-line marking
    send_frame(8'h10, 1'b0, 1'b0, 1'b1);
    take();
    cfg_dormant = 1'b1;
    @(negedge clk);
    send_frame(8'h20, 1'b0, 1'b0, 1'b1);
    chk("R9 short gap dropped", {7'b0, rx_valid}, 8'd0);
    repeat (100) @(negedge clk);
    send_frame(8'h30, 1'b0, 1'b0, 1'b1);
    chk("R9 after idle stored", {7'b0, rx_valid}, 8'd1);
    chk("R9 idle mark", {7'b0, st_addr}, 8'd1);
    chk("R9 idle data", rx_data, 8'h30);
    take();
    cfg_dormant = 1'b0;

    // R12: loopback takes txd_loc, rxd held low
    tb_loop = 1'b1;
    repeat (4) @(negedge clk);
    send_frame(8'h6D, 1'b0, 1'b0, 1'b1);
    chk("R12 loopback valid", {7'b0, rx_valid}, 8'd1);
    chk("R12 loopback data", rx_data, 8'h6D);
    take();
    tb_loop = 1'b0;
    repeat (4) @(negedge clk);

    // R13: software reset
    send_frame(8'h5E, 1'b0, 1'b0, 1'b1);
    sw_rst = 1'b1;
    @(negedge clk);
    chk("R13 swrst valid", {7'b0, rx_valid}, 8'd0);
    ln = 1'b0;
    repeat (40) @(negedge clk);
    chk("R13 swrst holds busy low", {7'b0, busy}, 8'd0);
    ln = 1'b1;
    repeat (2) @(negedge clk);
    sw_rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R13 idle after release", {7'b0, busy}, 8'd0);

    report();
  end
endmodule